// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into a programmable target over a serial pin pair. A one-cycle start pulse captures the number of image bytes. The block then pulls the active-low configuration request line low for a fixed hold time. At the end of the hold it confirms that the target has pulled its active-low status line low. It then releases the request and waits, with a time limit, for the target to release the status line.

After that handshake, bytes are taken one at a time from a valid/ready stream. Each byte is shifted out least significant bit first on a data pin, with a configuration clock that the block generates. The clock's low and high phases each last a programmable number of system clocks. Once the last byte is out, the block parks the clock low and samples the target's configuration-done input. If that input is high, the block sends a fixed burst of extra clock pulses.

A one-cycle completion pulse ends every run. A two-bit error code says whether the run succeeded or at which step it failed. Every failure returns the request, clock and data pins to their idle levels.

Top module: `serial_cfg_master`

## Requirements
- R1: After an accepted start, the request output `nCfgReq` is low for exactly HOLD_CLKS system clocks, where HOLD_CLKS = ceil(CLK_HZ * HOLD_NS / 1e9) with a minimum of 1.
- R2: If `nStatusIn` is high in the last cycle of the hold, the run ends with `errCode` = 1 and no rising edge on `serClk`.
- R3: After the hold, `nCfgReq` is high and `nStatusIn` is polled every cycle. If it stays low for WAIT_CLKS = CLK_HZ * TIMEOUT_US / 1e6 cycles, the run ends with `errCode` = 2, and `busy` is high with `nCfgReq` high for exactly WAIT_CLKS cycles.
- R4: Exactly `byteCount` bytes are accepted. Each byte is sent least significant bit first, one bit per rising edge of `serClk`, and `serData` holds the bit at that edge.
- R5: `serData` changes only when `serClk` is low both in the cycle of the change and in the cycle before it. Every high and low phase of `serClk` during a run lasts at least PHASE_CLKS cycles (PHASE_CLKS is raised to 2 if set lower).
- R6: After the last bit, `serClk` is held low for at least one phase and then `cfgDoneIn` is sampled. If it is low, the run ends with `errCode` = 3 and no further clock pulse.
- R7: If `cfgDoneIn` is high, exactly TRAIL_PULSES further clock pulses (high, then low) follow. The run then ends with `errCode` = 0 and `serClk` low, so that a run sees 8 * `byteCount` + TRAIL_PULSES rising edges.
- R8: Every run ends with `donePulse` high for exactly one cycle, in the first cycle in which `busy` is low. `errCode` is cleared to 0 on an accepted start and holds its value between runs.
- R9: `inReady` is high only while the shifter is empty, the configuration clock is between bytes and bytes remain. It drops in the cycle after a handshake. A `byteCount` of 0 sends no data bits.
- R10: A `start` pulse while `busy` is high has no effect: the run in progress keeps its byte count, its bit stream and its single completion pulse.
- R11: While the synchronous reset `rst` is high and in the cycle after it is released, `nCfgReq` = 1, `serClk` = 0, `serData` = 0, `busy` = 0, `inReady` = 0, `donePulse` = 0 and `errCode` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a run; taken only when idle |
| byteCount | input | COUNT_W | Number of image bytes, captured with `start` |
| inData | input | 8 | Image byte |
| inValid | input | 1 | `inData` is valid |
| inReady | output | 1 | The block takes `inData` at this edge when `inValid` is high |
| nCfgReq | output | 1 | Active-low configuration request to the target |
| nStatusIn | input | 1 | Active-low status from the target |
| cfgDoneIn | input | 1 | Configuration-done flag from the target |
| serClk | output | 1 | Generated configuration clock |
| serData | output | 1 | Serial configuration data |
| busy | output | 1 | A run is in progress |
| donePulse | output | 1 | One-cycle end-of-run strobe |
| errCode | output | 2 | 0 ok, 1 status not asserted, 2 release timeout, 3 done low |

## Verification
`nCfgReq` falls at the edge that takes `start` and rises HOLD_CLKS edges later. The bench therefore counts low samples taken at the falling edge of the system clock, not wall time. A release timeout lands WAIT_CLKS edges after `nCfgReq` rises, so the bench counts samples with `busy` and `nCfgReq` both high between those two events. Serial bits are captured on each rising edge of `serClk`. The bench also measures phase lengths in whole system-clock samples. `errCode` and the idle pin levels are checked in the sample where `donePulse` is first seen, which is the first cycle after the final register edge of the run.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int BYTE_BITS = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_BITS);

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_NO_STATUS = 2'd1,
    ERR_TIMEOUT   = 2'd2,
    ERR_NO_DONE   = 2'd3
  } errCode_e;

  typedef enum logic [1:0] {
    TMR_HOLD,
    TMR_WAIT,
    TMR_PHASE,
    TMR_PHASE_M2
  } tmrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     arm;
    logic     reqLow;
    logic     reqHigh;
    logic     tmrLoad;
    tmrSel_e  tmrSel;
    logic     takeByte;
    logic     putBit;
    logic     shiftBit;
    logic     clkLow;
    logic     clkHigh;
    logic     trailLoad;
    logic     trailDec;
    logic     finish;
    logic     fail;
    errCode_e failCode;
  } dpCtl_t;

  typedef struct packed {
    logic tmrZero;
    logic lastBit;
    logic noBytes;
    logic trailZero;
  } dpStat_t;

endpackage

// File: rtl/serial_cfg_dp.sv
module serial_cfg_dp
  import serial_cfg_pkg::*;
#(
  parameter int              COUNT_W  = 16,
  parameter int              TMR_W    = 8,
  parameter longint unsigned HOLD_LD  = 1,
  parameter longint unsigned WAIT_LD  = 1,
  parameter longint unsigned PHASE_LD = 1,
  parameter int              TRAIL_W  = 4,
  parameter int              TRAIL_LD = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpCtl_t               ctl,
  input  logic [COUNT_W-1:0]   byteCount,
  input  logic [BYTE_BITS-1:0] inData,
  output dpStat_t              stat,
  output logic                 nCfgReq,
  output logic                 serClk,
  output logic                 serData,
  output logic                 donePulse,
  output logic [1:0]           errCode
);

  localparam logic [TMR_W-1:0]   HOLD_V  = TMR_W'(HOLD_LD);
  localparam logic [TMR_W-1:0]   WAIT_V  = TMR_W'(WAIT_LD);
  localparam logic [TMR_W-1:0]   PHASE_V = TMR_W'(PHASE_LD);
  localparam logic [TMR_W-1:0]   PHM2_V  = TMR_W'(PHASE_LD - 1);
  localparam logic [TRAIL_W-1:0] TRAIL_V = TRAIL_W'(TRAIL_LD);

  logic [COUNT_W-1:0]   bytesLeft;
  logic [BYTE_BITS-1:0] shiftReg;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [TMR_W-1:0]     tmr;
  logic [TRAIL_W-1:0]   trailCnt;
  logic [TMR_W-1:0]     tmrNext;

  always_comb begin
    unique case (ctl.tmrSel)
      TMR_HOLD:  tmrNext = HOLD_V;
      TMR_WAIT:  tmrNext = WAIT_V;
      TMR_PHASE: tmrNext = PHASE_V;
      default:   tmrNext = PHM2_V;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bytesLeft <= '0;
      shiftReg  <= '0;
      bitIdx    <= '0;
      tmr       <= '0;
      trailCnt  <= '0;
    end else begin
      if (ctl.arm)           bytesLeft <= byteCount;
      else if (ctl.takeByte) bytesLeft <= bytesLeft - 1'b1;

      if (ctl.takeByte) begin
        shiftReg <= inData;
        bitIdx   <= '0;
      end else if (ctl.shiftBit) begin
        shiftReg <= shiftReg >> 1;
        bitIdx   <= bitIdx + 1'b1;
      end

      if (ctl.tmrLoad)       tmr <= tmrNext;
      else if (tmr != '0)    tmr <= tmr - 1'b1;

      if (ctl.trailLoad)     trailCnt <= TRAIL_V;
      else if (ctl.trailDec) trailCnt <= trailCnt - 1'b1;
    end
  end

  // pin and result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      nCfgReq   <= 1'b1;
      serClk    <= 1'b0;
      serData   <= 1'b0;
      donePulse <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      if (ctl.reqLow)                    nCfgReq <= 1'b0;
      else if (ctl.reqHigh || ctl.finish) nCfgReq <= 1'b1;

      if (ctl.clkLow || ctl.finish) serClk <= 1'b0;
      else if (ctl.clkHigh)         serClk <= 1'b1;

      if (ctl.finish)      serData <= 1'b0;
      else if (ctl.putBit) serData <= shiftReg[0];

      donePulse <= ctl.finish;

      if (ctl.arm)       errCode <= ERR_NONE;
      else if (ctl.fail) errCode <= ctl.failCode;
    end
  end

  assign stat.tmrZero   = (tmr == '0);
  assign stat.lastBit   = (bitIdx == BIT_IDX_W'(BYTE_BITS - 1));
  assign stat.noBytes   = (bytesLeft == '0);
  assign stat.trailZero = (trailCnt == '0);

endmodule

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
  import serial_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    nStatusIn,
  input  logic    cfgDoneIn,
  input  logic    inValid,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    busy,
  output logic    inReady
);

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_RELEASE, S_NEXT, S_PUT, S_LOW, S_HIGH,
    S_TAIL, S_CHECK, S_TR_HIGH, S_TR_LOW
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.arm     = 1'b1;
        ctl.reqLow  = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TMR_HOLD;
        nxt         = S_HOLD;
      end
      S_HOLD: if (stat.tmrZero) begin
        if (nStatusIn) begin
          ctl.finish   = 1'b1;
          ctl.fail     = 1'b1;
          ctl.failCode = ERR_NO_STATUS;
          nxt          = S_IDLE;
        end else begin
          ctl.reqHigh = 1'b1;
          ctl.tmrLoad = 1'b1;
          ctl.tmrSel  = TMR_WAIT;
          nxt         = S_RELEASE;
        end
      end
      S_RELEASE: begin
        if (nStatusIn) nxt = S_NEXT;
        else if (stat.tmrZero) begin
          ctl.finish   = 1'b1;
          ctl.fail     = 1'b1;
          ctl.failCode = ERR_TIMEOUT;
          nxt          = S_IDLE;
        end
      end
      S_NEXT: begin
        if (stat.noBytes) begin
          ctl.clkLow  = 1'b1;
          ctl.tmrLoad = 1'b1;
          ctl.tmrSel  = TMR_PHASE;
          nxt         = S_TAIL;
        end else if (inValid) begin
          ctl.takeByte = 1'b1;
          ctl.clkLow   = 1'b1;
          nxt          = S_PUT;
        end
      end
      S_PUT: begin
        // the clock fell one edge earlier; the bit goes out now
        ctl.putBit  = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TMR_PHASE_M2;
        nxt         = S_LOW;
      end
      S_LOW: if (stat.tmrZero) begin
        ctl.clkHigh = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TMR_PHASE;
        nxt         = S_HIGH;
      end
      S_HIGH: if (stat.tmrZero) begin
        if (stat.lastBit) nxt = S_NEXT;
        else begin
          ctl.shiftBit = 1'b1;
          ctl.clkLow   = 1'b1;
          nxt          = S_PUT;
        end
      end
      S_TAIL: if (stat.tmrZero) nxt = S_CHECK;
      S_CHECK: begin
        if (!cfgDoneIn) begin
          ctl.finish   = 1'b1;
          ctl.fail     = 1'b1;
          ctl.failCode = ERR_NO_DONE;
          nxt          = S_IDLE;
        end else begin
          ctl.trailLoad = 1'b1;
          ctl.clkHigh   = 1'b1;
          ctl.tmrLoad   = 1'b1;
          ctl.tmrSel    = TMR_PHASE;
          nxt           = S_TR_HIGH;
        end
      end
      S_TR_HIGH: if (stat.tmrZero) begin
        ctl.clkLow  = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TMR_PHASE;
        nxt         = S_TR_LOW;
      end
      S_TR_LOW: if (stat.tmrZero) begin
        if (stat.trailZero) begin
          ctl.finish = 1'b1;
          nxt        = S_IDLE;
        end else begin
          ctl.trailDec = 1'b1;
          ctl.clkHigh  = 1'b1;
          ctl.tmrLoad  = 1'b1;
          ctl.tmrSel   = TMR_PHASE;
          nxt          = S_TR_HIGH;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign inReady = (state == S_NEXT) && !stat.noBytes;

endmodule

// File: rtl/serial_cfg_master.sv
module serial_cfg_master
  import serial_cfg_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int HOLD_NS      = 2000,
  parameter int TIMEOUT_US   = 100_000,
  parameter int PHASE_CLKS   = 2,
  parameter int TRAIL_PULSES = 12,
  parameter int COUNT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [COUNT_W-1:0] byteCount,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               nCfgReq,
  input  logic               nStatusIn,
  input  logic               cfgDoneIn,
  output logic               serClk,
  output logic               serData,
  output logic               busy,
  output logic               donePulse,
  output logic [1:0]         errCode
);

  localparam longint unsigned HOLD_RAW =
    (longint'(CLK_HZ) * longint'(HOLD_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint unsigned HOLD_CLKS = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam longint unsigned WAIT_RAW =
    longint'(CLK_HZ) * longint'(TIMEOUT_US) / 64'd1_000_000;
  localparam longint unsigned WAIT_CLKS = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam longint unsigned PHASE_EFF = (PHASE_CLKS < 2) ? 2 : PHASE_CLKS;
  localparam longint unsigned TMR_MAX0  = (HOLD_CLKS > WAIT_CLKS) ? HOLD_CLKS : WAIT_CLKS;
  localparam longint unsigned TMR_MAX   = (TMR_MAX0 > PHASE_EFF) ? TMR_MAX0 : PHASE_EFF;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int TRAIL_N  = (TRAIL_PULSES < 1) ? 1 : TRAIL_PULSES;
  localparam int TRAIL_W  = $clog2(TRAIL_N + 1);

  dpCtl_t  ctl;
  dpStat_t stat;

  serial_cfg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .nStatusIn (nStatusIn),
    .cfgDoneIn (cfgDoneIn),
    .inValid   (inValid),
    .stat      (stat),
    .ctl       (ctl),
    .busy      (busy),
    .inReady   (inReady)
  );

  serial_cfg_dp #(
    .COUNT_W  (COUNT_W),
    .TMR_W    (TMR_W),
    .HOLD_LD  (HOLD_CLKS - 1),
    .WAIT_LD  (WAIT_CLKS - 1),
    .PHASE_LD (PHASE_EFF - 1),
    .TRAIL_W  (TRAIL_W),
    .TRAIL_LD (TRAIL_N - 1)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .byteCount (byteCount),
    .inData    (inData),
    .stat      (stat),
    .nCfgReq   (nCfgReq),
    .serClk    (serClk),
    .serData   (serData),
    .donePulse (donePulse),
    .errCode   (errCode)
  );

endmodule

// File: rtl/serial_cfg_checker.sv
module serial_cfg_checker #(
  parameter int COUNT_W      = 16,
  parameter int TRAIL_PULSES = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [COUNT_W-1:0] byteCount,
  input logic               inValid,
  input logic               inReady,
  input logic               nCfgReq,
  input logic               serClk,
  input logic               serData,
  input logic               busy,
  input logic               donePulse,
  input logic [1:0]         errCode
);

  logic [31:0]        riseCnt;
  logic [COUNT_W-1:0] runBytes;
  logic               clkQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      riseCnt  <= '0;
      runBytes <= '0;
      clkQ     <= 1'b0;
    end else begin
      clkQ <= serClk;
      if (start && !busy) begin
        riseCnt  <= '0;
        runBytes <= byteCount;
      end else if (serClk && !clkQ) begin
        riseCnt <= riseCnt + 1;
      end
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (nCfgReq && !serClk)) else $error("idle pins"); // R11

  AST_DATA_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(serData) |-> (!serClk && !$past(serClk))) else $error("data edge"); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse) else $error("done width"); // R8

  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (rst)
    donePulse |-> !busy) else $error("done busy"); // R8

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(errCode)) else $error("err held"); // R8

  AST_CLK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(serClk) |-> nCfgReq) else $error("clk with request low"); // R2

  AST_NO_BITS_EARLY_FAIL: assert property (@(posedge clk) disable iff (rst)
    (donePulse && (errCode == 2'd1 || errCode == 2'd2)) |-> (riseCnt == 0))
    else $error("bits before handshake"); // R3

  AST_PULSE_TOTAL: assert property (@(posedge clk) disable iff (rst)
    (donePulse && errCode == 2'd0) |-> (riseCnt == 32'(runBytes) * 8 + TRAIL_PULSES))
    else $error("pulse total"); // R7

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (inReady && inValid) |=> !inReady) else $error("ready held"); // R9

endmodule

bind serial_cfg_master serial_cfg_checker #(
  .COUNT_W      (COUNT_W),
  .TRAIL_PULSES (TRAIL_PULSES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .byteCount (byteCount),
  .inValid   (inValid),
  .inReady   (inReady),
  .nCfgReq   (nCfgReq),
  .serClk    (serClk),
  .serData   (serData),
  .busy      (busy),
  .donePulse (donePulse),
  .errCode   (errCode)
);

// File: tb/serial_cfg_master_bench.sv
`timescale 1ns/1ps
module serial_cfg_master_bench;

  // 2 MHz nominal: hold = ceil(2e6*2000/1e9) = 4, wait = 2e6*1000/1e6 = 2000
  localparam int HOLD_EXP  = 4;
  localparam int WAIT_EXP  = 2000;
  localparam int PHASE     = 3;
  localparam int TRAIL     = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] byteCount = '0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        nCfgReq;
  logic        nStatusIn = 1'b1;
  logic        cfgDoneIn = 1'b1;
  logic        serClk;
  logic        serData;
  logic        busy;
  logic        donePulse;
  logic [1:0]  errCode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serial_cfg_master #(
    .CLK_HZ(2_000_000), .HOLD_NS(2000), .TIMEOUT_US(1000),
    .PHASE_CLKS(PHASE), .TRAIL_PULSES(TRAIL), .COUNT_W(16)
  ) u_serial_cfg_master (
    .clk(clk), .rst(rst), .start(start), .byteCount(byteCount),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .nCfgReq(nCfgReq), .nStatusIn(nStatusIn), .cfgDoneIn(cfgDoneIn),
    .serClk(serClk), .serData(serData), .busy(busy),
    .donePulse(donePulse), .errCode(errCode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // target model
  int statusNever = 0;
  int relDelay    = 5;
  int relCnt      = 0;
  always @(negedge clk) begin
    if (!nCfgReq) begin
      relCnt    = 0;
      nStatusIn = (statusNever != 0);
    end else if (!nStatusIn) begin
      relCnt++;
      if (relCnt >= relDelay) nStatusIn = 1'b1;
    end
  end

  // monitors
  int riseCnt = 0;
  logic capBits [0:63];
  always @(posedge serClk) begin
    if (riseCnt < 64) capBits[riseCnt] = serData;
    riseCnt++;
  end

  int   lowReqCnt, relHighCnt, doneCnt, accCnt, glitchCnt, minHigh, minLow, runLen;
  logic prevClk = 1'b0, prevData = 1'b0;
  always @(negedge clk) begin
    if (!nCfgReq) lowReqCnt++;
    if (busy && nCfgReq && !nStatusIn) relHighCnt++;
    if (donePulse) doneCnt++;
    if (inValid && inReady) accCnt++;
    if (serData != prevData && (serClk || prevClk)) glitchCnt++;
    if (serClk == prevClk) runLen++;
    else begin
      if (prevClk && runLen < minHigh) minHigh = runLen;
      if (!prevClk && busy && runLen < minLow) minLow = runLen;
      runLen = 1;
    end
    prevClk  = serClk;
    prevData = serData;
  end

  task automatic clearMon();
    lowReqCnt = 0; relHighCnt = 0; doneCnt = 0; accCnt = 0; glitchCnt = 0;
    minHigh = 1000; minLow = 1000; runLen = 0; riseCnt = 0;
  endtask

  task automatic launch(input int cnt);
    @(negedge clk);
    clearMon();
    byteCount = 16'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int n, input logic [7:0] b [0:3]);
    for (int i = 0; i < n; i++) begin
      inData  = b[i];
      inValid = 1'b1;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!donePulse && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset();
    chk("R11 nCfgReq", nCfgReq, 1);
    chk("R11 serClk", serClk, 0);
    chk("R11 serData", serData, 0);
    chk("R11 busy", busy, 0);
    chk("R11 inReady", inReady, 0);
    chk("R11 donePulse", donePulse, 0);
    chk("R11 errCode", errCode, 0);
  endtask

  task automatic testLoad();
    logic [7:0] b [0:3];
    logic [7:0] got;
    b[0] = 8'hA5; b[1] = 8'h3C; b[2] = 8'h01; b[3] = 8'h00;
    statusNever = 0; relDelay = 5; cfgDoneIn = 1'b1;
    launch(3);
    fork
      feed(3, b);
      waitDone();
      begin
        repeat (40) @(negedge clk);
        byteCount = 16'd1;
        start = 1'b1;          // ignored: run in progress
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk("R1 hold cycles", lowReqCnt, HOLD_EXP);
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 8; j++) got[j] = capBits[k*8 + j];
      chk("R4 byte lsb first", got, b[k]);
    end
    chk("R4 R10 accepted bytes", accCnt, 3);
    chk("R7 R10 rising edges", riseCnt, 3*8 + TRAIL);
    chk("R5 data moved with clock high", glitchCnt, 0);
    chk("R5 min high phase", minHigh, PHASE);
    chk("R5 min low phase", minLow, PHASE);
    chk("R7 errCode ok", errCode, 0);
    chk("R7 clock parked low", serClk, 0);
    chk("R8 busy low at done", busy, 0);
    @(negedge clk);
    chk("R8 R10 one done pulse", doneCnt, 1);
    chk("R8 done one cycle", donePulse, 0);
  endtask

  task automatic testNoStatus();
    statusNever = 1;
    launch(2);
    inValid = 1'b1; inData = 8'hFF;
    waitDone();
    chk("R2 errCode", errCode, 1);
    chk("R2 no clock", riseCnt, 0);
    chk("R2 no byte taken", accCnt, 0);
    chk("R2 request idle", nCfgReq, 1);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 errCode held", errCode, 1);
    statusNever = 0;
  endtask

  task automatic testTimeout();
    relDelay = 100000;
    launch(1);
    waitDone();
    chk("R3 errCode", errCode, 2);
    chk("R3 wait cycles", relHighCnt, WAIT_EXP);
    chk("R3 no clock", riseCnt, 0);
    relDelay = 5;
  endtask

  task automatic testZeroBytes();
    relDelay = 1500;
    cfgDoneIn = 1'b1;
    launch(0);
    waitDone();
    chk("R8 errCode cleared by start", errCode, 0);
    chk("R9 zero count no bytes", accCnt, 0);
    chk("R7 trailing only", riseCnt, TRAIL);
    relDelay = 5;
  endtask

  task automatic testNoDone();
    logic [7:0] b [0:3];
    b[0] = 8'h5A; b[1] = 8'h00; b[2] = 8'h00; b[3] = 8'h00;
    cfgDoneIn = 1'b0;
    launch(1);
    fork
      feed(1, b);
      waitDone();
    join
    chk("R6 errCode", errCode, 3);
    chk("R6 no trailing pulses", riseCnt, 8);
    chk("R6 clock low", serClk, 0);
    chk("R9 ready off after count", inReady, 0);
    cfgDoneIn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testLoad();
    testNoStatus();
    testTimeout();
    testZeroBytes();
    testNoDone();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule